// File: doc/BRIEF.md
# Halt and Wait Idle Controller

This block governs when a processor core may fetch instructions while it sits in one of two idle modes. A halt command parks the core until an external interrupt request arrives with interrupts enabled, or until reset. On that wake-up the block passes control to the interrupt sequencer by pulsing `take_irq`. A wait command first looks at the active-low `test_n` input. If `test_n` is already low, execution carries on with no idle cycle. Otherwise the core idles until `test_n` goes low, and then `resume_next` pulses so that execution continues at the following instruction.

Both asynchronous inputs (`test_n` and `irq_req`) pass through a two-flop synchronizer before any decision uses them. Reset is asserted asynchronously and released through a two-flop synchronizer of its own. The idle modes differ in two ways. A halt wakes only on an enabled interrupt or on reset, and it goes to a service routine. A wait wakes only on `test_n`, and it goes to the next instruction. `fetch_en` stays low for every idle cycle.

Top module: `halt_wait_idle`

## Requirements
- R1: While reset is active and after it is released, `fetch_en` is 1 and both `resume_next` and `take_irq` are 0 until a command arrives.
- R2: A `halt_cmd` accepted in the running state drives `fetch_en` to 0 from the next cycle. `fetch_en` stays 0 for every cycle spent halted.
- R3: While halted, a synchronized `irq_req` of 1 together with `if_flag` of 1 ends the halt. An `irq_req` applied before clock edge a becomes visible after edge a+2. At that point `fetch_en` returns to 1 and `take_irq` is high for exactly that one cycle.
- R4: While halted with `if_flag` at 0, `irq_req` is ignored: `fetch_en` stays 0 and neither pulse fires.
- R5: Asserting `rst_n` low from any state sets `fetch_en` to 1 at once and clears both pulses. The core then stays in the running state.
- R6: A `wait_cmd` accepted while the synchronized `test_n` is 1 enters wait-idle, with `fetch_en` at 0 from the next cycle.
- R7: In wait-idle, a `test_n` driven to 0 before edge a ends the idle after edge a+2. At that point `fetch_en` returns to 1 and `resume_next` is high for one cycle.
- R8: A `wait_cmd` accepted while the synchronized `test_n` is 0 produces no idle cycle. `fetch_en` stays 1 and `resume_next` pulses for one cycle on the next cycle.
- R9: While in wait-idle, `irq_req` and `if_flag` have no effect. `take_irq` is only ever raised on leaving a halt.
- R10: When `halt_cmd` and `wait_cmd` arrive in the same cycle, the halt wins. Both commands are ignored while either idle state is active.
- R11: `resume_next` and `take_irq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_cmd | input | 1 | Halt command, one-cycle strobe |
| wait_cmd | input | 1 | Wait command, one-cycle strobe |
| test_n | input | 1 | Active-low external test level, asynchronous |
| irq_req | input | 1 | External interrupt request level, asynchronous |
| if_flag | input | 1 | Interrupt-enable flag from the core, synchronous |
| fetch_en | output | 1 | High when instruction fetch is allowed |
| resume_next | output | 1 | One-cycle pulse: continue at the next instruction |
| take_irq | output | 1 | One-cycle pulse: hand off to the interrupt sequencer |

## Verification
The assertions assume three things about the inputs. The command strobes and `if_flag` are synchronous to `clk`. `test_n` and `irq_req` may change at any time, because they are only examined after the synchronizer. The commands carry meaning only in the running state. The stimulus changes every input half a cycle away from the sampling edge. It toggles the asynchronous levels and the enable flag randomly from a fixed seed, and it fires commands in any state, including both in one cycle. Directed sequences add a masked halt, an immediate wait and a reset applied during a halt.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAIT = 2'd2
  } idle_state_e;

  localparam int unsigned SYNC_DEPTH_DEFAULT = 2;
endpackage

// File: rtl/hw_sync.sv
module hw_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = pipe_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= RST_VAL;
        else        pipe_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q = pipe_q[LAST];
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
  import idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic wait_cmd,
  input  logic test_s,
  input  logic irq_s,
  input  logic if_flag,
  output logic fetch_en,
  output logic resume_next,
  output logic take_irq
);
  idle_state_e state_q, state_d;
  logic        resume_q, resume_d;
  logic        irq_q, irq_d;

  always_comb begin
    state_d  = state_q;
    resume_d = 1'b0;
    irq_d    = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt_cmd) begin
          state_d = ST_HALT;
        end else if (wait_cmd) begin
          if (test_s) state_d  = ST_WAIT;
          else        resume_d = 1'b1;
        end
      end
      ST_HALT: begin
        if (irq_s && if_flag) begin
          state_d = ST_RUN;
          irq_d   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!test_s) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      resume_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      irq_q    <= irq_d;
    end
  end

  assign fetch_en    = (state_q == ST_RUN);
  assign resume_next = resume_q;
  assign take_irq    = irq_q;

  // R2
  halt_enters_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && halt_cmd) |=> !fetch_en);
  // R4
  masked_irq_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !if_flag) |=> (!fetch_en && !take_irq));
  // R3
  take_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);
  // R8
  fast_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !halt_cmd && wait_cmd && !test_s) |=> (fetch_en && resume_next));
  // R9
  irq_only_from_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> !take_irq);
  // R11
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_next && take_irq));
  // R7
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !test_s) |=> (fetch_en && resume_next));
endmodule

// File: rtl/halt_wait_idle.sv
module halt_wait_idle
  import idle_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEFAULT,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd,
  input  logic wait_cmd,
  input  logic test_n,
  input  logic irq_req,
  input  logic if_flag,
  output logic fetch_en,
  output logic resume_next,
  output logic take_irq
);
  localparam int unsigned ASYNC_W = 2;
  localparam logic [ASYNC_W-1:0] ASYNC_RST = 2'b10; // {test_n idle high, irq low}

  logic                rst_n_int;
  logic [ASYNC_W-1:0]  async_s;

  hw_sync #(.WIDTH(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  hw_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(ASYNC_RST)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     ({test_n, irq_req}),
    .q     (async_s)
  );

  idle_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .halt_cmd    (halt_cmd),
    .wait_cmd    (wait_cmd),
    .test_s      (async_s[1]),
    .irq_s       (async_s[0]),
    .if_flag     (if_flag),
    .fetch_en    (fetch_en),
    .resume_next (resume_next),
    .take_irq    (take_irq)
  );

  // R5
  reset_runs_chk: assert property (@(posedge clk) !rst_n |-> (fetch_en && !resume_next && !take_irq));
endmodule

// File: tb/tb_halt_wait_idle.sv
module tb_halt_wait_idle;
  logic clk = 1'b0;
  logic rst_n, halt_cmd, wait_cmd, test_n, irq_req, if_flag;
  logic fetch_en, resume_next, take_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  halt_wait_idle dut (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .wait_cmd(wait_cmd),
    .test_n(test_n), .irq_req(irq_req), .if_flag(if_flag),
    .fetch_en(fetch_en), .resume_next(resume_next), .take_irq(take_irq)
  );

  // reference model built from the requirements
  int    m_st;   // 0 run, 1 halt, 2 wait
  int    m_hold;
  logic  ms1t, ms2t, ms1i, ms2i, m_res, m_tk;
  string m_tag;

  function automatic string tag_of(int st, logic h, logic w, logic t, logic i, logic f);
    if (st == 1) return (i && f) ? "R3" : (f ? "R2" : "R4");
    if (st == 2) return t ? "R9" : "R7";
    if (h && w)  return "R10";
    if (h)       return "R2";
    if (w)       return t ? "R6" : "R8";
    return "R1";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_hold <= 0; ms1t <= 1'b1; ms2t <= 1'b1; ms1i <= 1'b0; ms2i <= 1'b0;
      m_res <= 1'b0; m_tk <= 1'b0; m_tag <= "R5";
    end else if (m_hold < 2) begin
      m_hold <= m_hold + 1;
      m_tag  <= "R1";
    end else begin
      ms1t <= test_n; ms2t <= ms1t; ms1i <= irq_req; ms2i <= ms1i;
      m_res <= 1'b0; m_tk <= 1'b0;
      m_tag <= tag_of(m_st, halt_cmd, wait_cmd, ms2t, ms2i, if_flag);
      case (m_st)
        0: if (halt_cmd) m_st <= 1;
           else if (wait_cmd) begin
             if (ms2t) m_st <= 2; else m_res <= 1'b1;
           end
        1: if (ms2i && if_flag) begin m_st <= 0; m_tk <= 1'b1; end
        default: if (!ms2t) begin m_st <= 0; m_res <= 1'b1; end
      endcase
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(m_tag, "fetch_en", fetch_en, (m_st == 0));
    check(m_tag, "resume_next", resume_next, m_res);
    check(m_tag, "take_irq", take_irq, m_tk);
    check("R11", "pulse overlap", resume_next & take_irq, 1'b0);
  endtask

  task automatic step(logic h, logic w);
    halt_cmd = h; wait_cmd = w;
    @(posedge clk);
    @(negedge clk);
    check_all();
    halt_cmd = 1'b0; wait_cmd = 1'b0;
  endtask

  task automatic idle_steps(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; halt_cmd = 1'b0; wait_cmd = 1'b0;
    test_n = 1'b1; irq_req = 1'b0; if_flag = 1'b0;
    #1;
    check("R5", "fetch_en in reset", fetch_en, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_steps(4);   // R1: reset release holds running state

    // R4 then R3: halt with interrupts masked, then enabled
    step(1'b1, 1'b0);
    irq_req = 1'b1;
    idle_steps(5);
    if_flag = 1'b1;
    idle_steps(2);
    irq_req = 1'b0;
    idle_steps(3);

    // R8: test_n already low
    test_n = 1'b0;
    idle_steps(3);
    step(1'b0, 1'b1);
    idle_steps(2);

    // R6, R9, R7: wait idle ignores irq, wakes on test_n
    test_n = 1'b1;
    idle_steps(3);
    step(1'b0, 1'b1);
    irq_req = 1'b1;
    idle_steps(4);
    irq_req = 1'b0;
    test_n = 1'b0;
    idle_steps(4);

    // R10: both commands together, then commands while halted
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);

    // R5: reset while halted
    rst_n = 1'b0;
    #1;
    check("R5", "fetch_en on reset from halt", fetch_en, 1'b1);
    check("R5", "take_irq on reset", take_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_steps(3);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic h, w;
      if ($urandom_range(9) == 0)  test_n  = ~test_n;
      if ($urandom_range(11) == 0) irq_req = ~irq_req;
      if ($urandom_range(19) == 0) if_flag = ~if_flag;
      h = ($urandom_range(7) == 0);
      w = ($urandom_range(6) == 0);
      step(h, w);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule